// File: doc/BRIEF.md
# Dual-Width Up Counter with Selectable Tick Source

This block is an up-counter that works either on its low byte alone (narrow mode) or on a full 16-bit word (wide mode). A 3-bit source field chooses what advances it. The choices are nothing, one of five divided-clock strobes from an external prescaler, or a falling or rising edge on an asynchronous input pin. The pin is first brought into the system clock domain, then edge-detected.

The counter counts up until it reaches its end value, then returns to zero on the next tick. The end value is either the largest value that fits the active width or a compare word. In narrow mode the compare word is one byte. In wide mode two byte registers join to form it. Two sticky flags drive the interrupt outputs. One is set when the counter returns to zero from its end value. The other is set when the counter matches the compare word. Software controls everything through a small register bus. Writes take effect on the next clock. Reads are combinational.

Top module: `dual_timer`

## Requirements
- R1: Source field values 1 to 5 select strobe bits 0 to 4 of `tick_tap`. Each clock with the selected bit high adds one to the counter. Strobes on bits that are not selected leave the counter unchanged.
- R2: With source field 0, the counter keeps its value whatever the strobe and pin inputs do.
- R3: Source field 6 counts falling edges of `ext_pin` and source field 7 counts rising edges. The count for an edge becomes visible after the third rising clock edge that follows the pin change, and not earlier.
- R4: In narrow mode (control bit 3 = 0) only the counter's low byte counts. The high byte is never changed by counting. With the fixed end value, 0xFF is followed by 0x00.
- R5: In wide mode (control bit 3 = 1) all 16 bits count. With the fixed end value, 0xFFFF is followed by 0x0000.
- R6: Control bit 4 = 1 makes the end value the compare word. In narrow mode the compare word is register 3. In wide mode it is {register 4, register 3}. A counter already above the end value counts on to the width's maximum and rolls to zero without setting the overflow flag.
- R7: The overflow flag (register 5 bit 0, also `irq_ovf`) is set by a tick taken at the end value. It stays set until a write of 1 to that bit. A set and a clear in the same cycle leave it set.
- R8: The match flag (register 5 bit 1, also `irq_cmp`) is set by a tick taken while the counter equals the compare word. It is sticky and cleared by writing 1, in the same way as the overflow flag.
- R9: A write to register 1 (counter low byte) or register 2 (counter high byte) loads that byte. In the same cycle it cancels any tick: there is no increment and no flag is set.
- R10: Register map: 0 is control (bits 2:0 source, bit 3 wide, bit 4 end-value select), 1 and 2 are the counter bytes, 3 and 4 are the compare bytes, 5 holds the flags. Unused bits and addresses read 0. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_tap | input | 5 | Prescaler strobes for divisions 1, 8, 64, 256, 1024 |
| ext_pin | input | 1 | Asynchronous external count input |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_ovf | output | 1 | Overflow flag |
| irq_cmp | output | 1 | Compare-match flag |

## Verification
Directed sequences place the counter next to each end value: narrow fixed, wide fixed, and compare-based in both widths. They tell a correct wrap apart from an off-by-one or a wrong-width wrap, and they confirm that the high byte is left alone in narrow mode. Strobe patterns that pulse only the unselected taps tell source decoding apart from plain counting. A single pin transition followed by reads on each cycle pins the synchroniser latency to exactly three edges. A long random run mixes strobes, pin toggles, source changes and bus writes, including writes that collide with ticks and flag clears that collide with flag sets. It separates the correct priorities from the other orderings.

// File: rtl/dual_timer.sv
module dual_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] tick_tap,
  input  logic       ext_pin,
  input  logic [2:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_ovf,
  output logic       irq_cmp
);
  logic [2:0]  src;
  logic        wide, top_cmp;
  logic [15:0] cnt;
  logic [7:0]  cmp_lo, cmp_hi;
  logic        ovf_q, cmp_q;
  logic        s1, s2, s3;
  logic        tick;

  wire wr_ctrl = bus_we && bus_addr == 3'd0;
  wire wr_cnt  = bus_we && (bus_addr == 3'd1 || bus_addr == 3'd2);
  wire wr_flag = bus_we && bus_addr == 3'd5;

  always_comb begin
    case (src)
      3'd1:    tick = tick_tap[0];
      3'd2:    tick = tick_tap[1];
      3'd3:    tick = tick_tap[2];
      3'd4:    tick = tick_tap[3];
      3'd5:    tick = tick_tap[4];
      3'd6:    tick = s3 & ~s2;
      3'd7:    tick = s2 & ~s3;
      default: tick = 1'b0;
    endcase
  end

  wire [15:0] cur    = wide ? cnt : {8'h00, cnt[7:0]};
  wire [15:0] cmpv   = wide ? {cmp_hi, cmp_lo} : {8'h00, cmp_lo};
  wire [15:0] top    = top_cmp ? cmpv : (wide ? 16'hFFFF : 16'h00FF);
  wire        at_top = cur == top;
  wire        step   = tick & ~wr_cnt;
  wire [15:0] nxt    = at_top ? 16'h0000 : cur + 16'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0; wide <= 1'b0; top_cmp <= 1'b0;
      cnt <= '0; cmp_lo <= '0; cmp_hi <= '0;
      ovf_q <= 1'b0; cmp_q <= 1'b0;
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
    end else begin
      s1 <= ext_pin; s2 <= s1; s3 <= s2;
      if (wr_ctrl) {top_cmp, wide, src} <= bus_wdata[4:0];
      if (bus_we && bus_addr == 3'd3) cmp_lo <= bus_wdata;
      if (bus_we && bus_addr == 3'd4) cmp_hi <= bus_wdata;
      if (wr_cnt) begin
        if (bus_addr == 3'd1) cnt[7:0] <= bus_wdata;
        else                  cnt[15:8] <= bus_wdata;
      end else if (step) begin
        if (wide) cnt <= nxt;
        else      cnt[7:0] <= nxt[7:0];
      end
      ovf_q <= (ovf_q & ~(wr_flag & bus_wdata[0])) | (step & at_top);
      cmp_q <= (cmp_q & ~(wr_flag & bus_wdata[1])) | (step & (cur == cmpv));
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {3'b000, top_cmp, wide, src};
      3'd1:    bus_rdata = cnt[7:0];
      3'd2:    bus_rdata = cnt[15:8];
      3'd3:    bus_rdata = cmp_lo;
      3'd4:    bus_rdata = cmp_hi;
      3'd5:    bus_rdata = {6'b000000, cmp_q, ovf_q};
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq_ovf = ovf_q;
  assign irq_cmp = cmp_q;

  p_stop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 3'd0 && !wr_cnt) |=> $stable(cnt));

  p_wrap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_cnt && !wr_ctrl && at_top) |=> (cur == 16'h0000 && irq_ovf));

  p_narrow_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !wr_cnt) |=> $stable(cnt[15:8]));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd1) |=> cnt[7:0] == $past(bus_wdata));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf && !(wr_flag && bus_wdata[0])) |=> irq_ovf);

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wide && !wr_cnt && !wr_ctrl && !at_top) |=> cnt[7:0] == $past(cnt[7:0]) + 8'd1);

  p_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt));
endmodule

// File: tb/dual_timer_test.sv
module dual_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] tick_tap = '0;
  logic ext_pin = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_ovf, irq_cmp;

  dual_timer uut (.clk(clk), .rst_n(rst_n), .tick_tap(tick_tap), .ext_pin(ext_pin),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [2:0] m_src; logic m_wide, m_top;
  logic [15:0] m_cnt; logic [7:0] m_ca, m_cb;
  logic m_ovf, m_cmp, p1, p2, p3;

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {3'b000, m_top, m_wide, m_src};
      3'd1: return m_cnt[7:0];
      3'd2: return m_cnt[15:8];
      3'd3: return m_ca;
      3'd4: return m_cb;
      3'd5: return {6'b0, m_cmp, m_ovf};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic m_tick(input logic [4:0] taps);
    case (m_src)
      3'd0: return 1'b0;
      3'd6: return p3 & ~p2;
      3'd7: return p2 & ~p3;
      default: return taps[m_src - 3'd1];
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic we, input logic [2:0] a,
                     input logic [7:0] wd, input logic [4:0] taps, input logic pin);
    logic [15:0] cur, cv, top, nc;
    logic t, wc, wf, at;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = wd; tick_tap = taps; ext_pin = pin;
    #1;
    chk(tag, bus_rdata, m_read(a));
    chk({tag, " irq"}, {6'b0, irq_cmp, irq_ovf}, {6'b0, m_cmp, m_ovf});
    t  = m_tick(taps);
    wc = we && (a == 3'd1 || a == 3'd2);
    wf = we && a == 3'd5;
    cur = m_wide ? m_cnt : {8'h00, m_cnt[7:0]};
    cv  = m_wide ? {m_cb, m_ca} : {8'h00, m_ca};
    top = m_top ? cv : (m_wide ? 16'hFFFF : 16'h00FF);
    at  = cur == top;
    nc  = m_cnt;
    if (wc) begin
      if (a == 3'd1) nc[7:0] = wd; else nc[15:8] = wd;
    end else if (t) begin
      if (m_wide) nc = at ? 16'h0 : cur + 16'd1;
      else nc[7:0] = at ? 8'h0 : m_cnt[7:0] + 8'd1;
    end
    @(posedge clk);
    m_ovf = (m_ovf & ~(wf & wd[0])) | (t & ~wc & at);
    m_cmp = (m_cmp & ~(wf & wd[1])) | (t & ~wc & (cur == cv));
    m_cnt = nc;
    if (we && a == 3'd0) {m_top, m_wide, m_src} = wd[4:0];
    if (we && a == 3'd3) m_ca = wd;
    if (we && a == 3'd4) m_cb = wd;
    p3 = p2; p2 = p1; p1 = pin;
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [7:0] d);
    cyc(tag, 1'b1, a, d, 5'b0, ext_pin);
  endtask
  task automatic rd(input string tag, input logic [2:0] a, input logic [4:0] taps);
    cyc(tag, 1'b0, a, 8'h00, taps, ext_pin);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    m_src = 0; m_wide = 0; m_top = 0; m_cnt = 0; m_ca = 0; m_cb = 0;
    m_ovf = 0; m_cmp = 0; p1 = 0; p2 = 0; p3 = 0;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    for (int a = 0; a < 8; a++) rd("R10 reset", 3'(a), 5'b0);

    wr("R10 ctrl", 3'd0, 8'hFF); rd("R10 ctrl rb", 3'd0, 5'b0);
    wr("R10 cmpA", 3'd3, 8'hA5); rd("R10 cmpA rb", 3'd3, 5'b0);
    wr("R10 ctrl", 3'd0, 8'h00);
    for (int i = 0; i < 4; i++) rd("R2 stopped", 3'd1, 5'h1F);

    wr("R1 src3", 3'd0, 8'h03);
    for (int i = 0; i < 3; i++) rd("R1 other taps", 3'd1, 5'b11011);
    for (int i = 0; i < 3; i++) rd("R1 selected tap", 3'd1, 5'b00100);
    wr("R1 src1", 3'd0, 8'h01);
    for (int i = 0; i < 3; i++) rd("R1 tap0", 3'd1, 5'b00001);

    cyc("R9 write vs tick", 1'b1, 3'd1, 8'h40, 5'b00001, 1'b0);
    rd("R9 loaded", 3'd1, 5'b0); rd("R9 no flag", 3'd5, 5'b0);

    wr("R4 hi", 3'd2, 8'h12); wr("R4 lo", 3'd1, 8'hFE);
    for (int i = 0; i < 3; i++) rd("R4 narrow wrap", 3'd1, 5'b00001);
    rd("R4 hi kept", 3'd2, 5'b0); rd("R7 ovf set", 3'd5, 5'b0);
    cyc("R7 set beats clear", 1'b1, 3'd5, 8'h01, 5'b0, 1'b0);
    wr("R4 lo", 3'd1, 8'hFF);
    cyc("R7 set beats clear", 1'b1, 3'd5, 8'h03, 5'b00001, 1'b0);
    rd("R7 still set", 3'd5, 5'b0);
    wr("R7 clear", 3'd5, 8'h03); rd("R7 cleared", 3'd5, 5'b0);

    wr("R5 wide", 3'd0, 8'h09); wr("R5 hi", 3'd2, 8'hFF); wr("R5 lo", 3'd1, 8'hFE);
    for (int i = 0; i < 3; i++) begin rd("R5 lo", 3'd1, 5'b00001); rd("R5 hi", 3'd2, 5'b0); end

    wr("R6 narrow cmp", 3'd0, 8'h11); wr("R6 cmpA", 3'd3, 8'h03); wr("R6 lo", 3'd1, 8'h00);
    for (int i = 0; i < 6; i++) rd("R6 narrow top", 3'd1, 5'b00001);
    rd("R8 match flag", 3'd5, 5'b0); wr("R8 clear", 3'd5, 8'h03);
    wr("R6 above top", 3'd1, 8'hFE);
    for (int i = 0; i < 3; i++) rd("R6 roll no ovf", 3'd5, 5'b00001);
    wr("R6 wide cmp", 3'd0, 8'h19); wr("R6 cmpB", 3'd4, 8'h01); wr("R6 cmpA", 3'd3, 8'h02);
    wr("R6 hi", 3'd2, 8'h01); wr("R6 lo", 3'd1, 8'h00);
    for (int i = 0; i < 4; i++) begin rd("R6 wide top", 3'd1, 5'b00001); rd("R6 wide hi", 3'd2, 5'b0); end
    rd("R8 wide match", 3'd5, 5'b0);

    wr("R3 rising", 3'd0, 8'h07); wr("R3 zero", 3'd1, 8'h00);
    cyc("R3 pin rise", 1'b0, 3'd1, 8'h00, 5'b0, 1'b1);
    for (int i = 0; i < 4; i++) rd("R3 latency", 3'd1, 5'b0);
    wr("R3 falling", 3'd0, 8'h06);
    cyc("R3 pin fall", 1'b0, 3'd1, 8'h00, 5'b0, 1'b0);
    for (int i = 0; i < 4; i++) rd("R3 latency fall", 3'd1, 5'b0);

    for (int i = 0; i < 4000; i++) begin
      logic we; logic [2:0] a; logic [7:0] d; logic pin;
      we = ($urandom % 8) == 0;
      a = 3'($urandom % 7);
      d = 8'($urandom);
      if (a == 3'd3 || a == 3'd4) d = d & 8'h07;
      if (a == 3'd0) d = d & 8'h1F;
      pin = (($urandom % 4) == 0) ? ~ext_pin : ext_pin;
      cyc("R1 R8 R9 random", we, a, d, 5'($urandom), pin);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule